// File: doc/BRIEF.md
# SDRAM Command Timing Checker

This block watches an already decoded command stream for a two-bank SDRAM and reports any command that arrives sooner than the device allows. Each clock it samples a command code, a bank select and a strobe that marks the cycle of the final data word of a write burst. Row timings are given as picosecond parameters together with the clock period. At elaboration each timing becomes a clock count, rounded up to the next whole clock. Per-bank age counters then measure the distance from every relevant earlier event.

Each rule has its own registered violation bit. A violation bit is high for exactly the one cycle that follows the offending command. A separate `ok_o` pulse, in that same cycle, confirms a command that broke no rule. Besides the basic row rules, the checker covers three delays measured from the last write data. It also covers a read-to-precharge window of CL+BL-2 clocks and a maximum row-open time.

Top module: `sdr_cmd_guard`

## Requirements
- R1: After reset `viol_o` and `ok_o` are zero, and every timer counts as long expired, so the first ACTIVE, READ, WRITE, PRECHARGE or BURST STOP raises no timing bit.
- R2: Command codes on `cmd_i` are 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE and 5 BURST STOP; 6 and 7 act as NOP. The cycle after a code 1 to 5 has `ok_o`=1 exactly when none of the command bits (every bit except bit 5) is set. Bit positions in `viol_o`: 0 RRD, 1 RCD, 2 RP, 3 RAS-min, 4 RC, 5 RAS-max, 6 bank-state, 7 write-data-to-column, 8 write-data-to-precharge, 9 write-data-to-burst-stop, 10 read-to-precharge.
- R3: ACTIVE fewer than ceil(tRRD/tCK) clocks after an ACTIVE to the other bank sets bit 0.
- R4: READ or WRITE to an open bank fewer than ceil(tRCD/tCK) clocks after that bank's ACTIVE sets bit 1.
- R5: ACTIVE to a bank fewer than ceil(tRP/tCK) clocks after its PRECHARGE sets bit 2, and fewer than ceil(tRC/tCK) clocks after its previous ACTIVE sets bit 4.
- R6: PRECHARGE to an open bank fewer than ceil(tRAS/tCK) clocks after its ACTIVE sets bit 3.
- R7: PRECHARGE to an open bank fewer than CL+BL-2 clocks after a READ to that bank sets bit 10.
- R8: READ or WRITE fewer than 1 clock after the last-write-data strobe sets bit 7; a strobe in the same cycle counts as distance 0.
- R9: PRECHARGE to the bank of the most recent WRITE fewer than 2 clocks after the strobe sets bit 8; PRECHARGE to the other bank is not affected.
- R10: BURST STOP fewer than 1 clock after the strobe sets bit 9.
- R11: READ or WRITE to a closed bank, or ACTIVE to an open bank, sets bit 6; PRECHARGE to a closed bank is legal and sets nothing.
- R12: A bank left open sets bit 5 once, in the cycle after the clock that lies ceil(tRAS_max/tCK) clocks past its ACTIVE, unless that bank is precharged in that very clock.
- R13: Every violation bit is high for one cycle only, when the next command is legal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous reset, active low |
| cmd_i | input | 3 | Decoded command code (R2) |
| bank_i | input | 1 | Bank addressed by the command |
| wr_last_i | input | 1 | High in the cycle of the last write data word |
| viol_o | output | 11 | One registered flag per rule (R2 positions) |
| ok_o | output | 1 | Pulse confirming a legal command |

## Verification
The row-open limit runs off its own timer and does not depend on the command stream. Its expiry on one bank can therefore land in the same cycle as a legal command to the other bank. The bench opens bank 0 and counts exactly up to the limit, then issues ACTIVE to bank 1 in that cycle. It expects bit 5 and `ok_o` together, with no command bit. A second run precharges bank 0 in the expiry cycle and expects the flag to be suppressed while `ok_o` is still raised.

// File: rtl/sdr_guard_pkg.sv
// Shared definitions for the SDRAM command timing checker: command codes,
// violation bit positions and elaboration-time clock conversion helpers.
// Assumes timings and clock period are given in picoseconds.
package sdr_guard_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_BST = 3'd5
    } sdr_cmd_e;

    localparam int V_RRD   = 0;
    localparam int V_RCD   = 1;
    localparam int V_RP    = 2;
    localparam int V_RAS   = 3;
    localparam int V_RC    = 4;
    localparam int V_RASMX = 5;
    localparam int V_STATE = 6;
    localparam int V_WCOL  = 7;
    localparam int V_WPRE  = 8;
    localparam int V_WBST  = 9;
    localparam int V_RDPRE = 10;
    localparam int NVIOL   = 11;

    // Minimum clocks for a time span: divide and round up.
    function automatic int clocks_for(input int span_ps, input int tck_ps);
        return (span_ps + tck_ps - 1) / tck_ps;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdr_guard_age.sv
// Saturating age counter. Reads 1 in the cycle after clr_i, grows by one
// per clock and stops at MAXV. Resets to MAXV so a never-seen event
// appears long past. Assumes MAXV fits in AW bits.
module sdr_guard_age #(
    parameter int AW   = 8,
    parameter int MAXV = 255
) (
    input  logic          clk_i,
    input  logic          rst_n_i,
    input  logic          clr_i,
    output logic [AW-1:0] age_o
);
    localparam logic [AW-1:0] TOP = AW'(MAXV);

    logic [AW-1:0] age_q;

    // Restart on event, otherwise count up to saturation.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)          age_q <= TOP;
        else if (clr_i)        age_q <= AW'(1);
        else if (age_q < TOP)  age_q <= age_q + 1'b1;
    end

    assign age_o = age_q;

    assert_age_range_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $past(rst_n_i) |-> (age_q != '0) && (age_q <= TOP));

endmodule

// File: rtl/sdr_guard_bank.sv
// Per-bank tracker: open/closed state, ages since ACTIVE, since a closing
// PRECHARGE and since READ, plus the row-open limit detector.
// Assumes its inputs are already qualified by the bank select.
module sdr_guard_bank #(
    parameter int AW       = 16,
    parameter int SAT      = 20001,
    parameter int N_RASMAX = 20000
) (
    input  logic          clk_i,
    input  logic          rst_n_i,
    input  logic          act_i,
    input  logic          rd_i,
    input  logic          pre_i,
    output logic          open_o,
    output logic [AW-1:0] age_act_o,
    output logic [AW-1:0] age_pre_o,
    output logic [AW-1:0] age_rd_o,
    output logic          ras_max_o
);
    localparam logic [AW-1:0] L_RASMAX = AW'(N_RASMAX);

    logic open_q;

    // Row state: ACTIVE opens, PRECHARGE closes.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)   open_q <= 1'b0;
        else if (act_i) open_q <= 1'b1;
        else if (pre_i) open_q <= 1'b0;
    end

    sdr_guard_age #(.AW(AW), .MAXV(SAT)) u_age_act (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .clr_i(act_i), .age_o(age_act_o));

    sdr_guard_age #(.AW(AW), .MAXV(SAT)) u_age_pre (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .clr_i(pre_i && open_q), .age_o(age_pre_o));

    sdr_guard_age #(.AW(AW), .MAXV(SAT)) u_age_rd (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .clr_i(rd_i), .age_o(age_rd_o));

    // Row-open limit reached this clock and not closed right now.
    assign ras_max_o = open_q && (age_act_o == L_RASMAX) && !pre_i;
    assign open_o    = open_q;

    assert_open_by_act_R11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(open_q) |-> $past(act_i));

    assert_rasmax_once_R12: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ras_max_o |=> !ras_max_o);

endmodule

// File: rtl/sdr_guard_wdata.sv
// Write-data distance tracker: age since the last-write-data strobe and the
// bank that burst belonged to. The strobe is taken to close the burst of
// the most recent WRITE. A strobe in the current cycle reads as distance 0.
module sdr_guard_wdata #(
    parameter int AW  = 16,
    parameter int SAT = 20001,
    parameter int BW  = 1
) (
    input  logic          clk_i,
    input  logic          rst_n_i,
    input  logic          wr_i,
    input  logic [BW-1:0] wr_bank_i,
    input  logic          strobe_i,
    output logic [AW-1:0] dist_o,
    output logic [BW-1:0] bank_o
);
    logic [AW-1:0] age;
    logic [BW-1:0] wr_bank_q;
    logic [BW-1:0] wd_bank_q;

    sdr_guard_age #(.AW(AW), .MAXV(SAT)) u_age_wd (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .clr_i(strobe_i), .age_o(age));

    // Remember the bank of the latest WRITE and of the finished burst.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            wr_bank_q <= '0;
            wd_bank_q <= '0;
        end else begin
            if (wr_i)     wr_bank_q <= wr_bank_i;
            if (strobe_i) wd_bank_q <= wr_bank_q;
        end
    end

    assign dist_o = strobe_i ? '0 : age;
    assign bank_o = strobe_i ? wr_bank_q : wd_bank_q;

    assert_wd_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $past(strobe_i) && !strobe_i |-> dist_o == AW'(1));

endmodule

// File: rtl/sdr_cmd_guard.sv
// SDRAM command timing checker for two banks. Converts picosecond timings
// to clock counts at elaboration, tracks per-bank and write-data ages, and
// registers one violation flag per rule plus an ok pulse per legal command.
// Assumes CAS_LAT is 2 or 3 and BURST_LEN is 1, 2, 4 or 8.
module sdr_cmd_guard
    import sdr_guard_pkg::*;
#(
    parameter int T_CK_PS     = 5000,
    parameter int T_RRD_PS    = 10000,
    parameter int T_RCD_PS    = 15000,
    parameter int T_RP_PS     = 15000,
    parameter int T_RAS_PS    = 40000,
    parameter int T_RASMX_PS  = 100000000,
    parameter int T_RC_PS     = 55000,
    parameter int CAS_LAT     = 3,
    parameter int BURST_LEN   = 4
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [2:0]       cmd_i,
    input  logic [0:0]       bank_i,
    input  logic             wr_last_i,
    output logic [NVIOL-1:0] viol_o,
    output logic             ok_o
);
    localparam int NBANK    = 2;
    localparam int BW       = 1;
    localparam int N_RRD    = clocks_for(T_RRD_PS, T_CK_PS);
    localparam int N_RCD    = clocks_for(T_RCD_PS, T_CK_PS);
    localparam int N_RP     = clocks_for(T_RP_PS, T_CK_PS);
    localparam int N_RAS    = clocks_for(T_RAS_PS, T_CK_PS);
    localparam int N_RASMAX = clocks_for(T_RASMX_PS, T_CK_PS);
    localparam int N_RC     = clocks_for(T_RC_PS, T_CK_PS);
    localparam int N_CDL    = 1;
    localparam int N_RDL    = 2;
    localparam int N_BDL    = 1;
    localparam int N_RDPRE  = CAS_LAT + BURST_LEN - 2;
    localparam int SAT      = imax(imax(imax(N_RASMAX, N_RC), imax(N_RCD, N_RRD)),
                                   imax(imax(N_RP, N_RAS), N_RDPRE)) + 1;
    localparam int AW       = $clog2(SAT + 1);

    localparam logic [AW-1:0] L_RRD   = AW'(N_RRD);
    localparam logic [AW-1:0] L_RCD   = AW'(N_RCD);
    localparam logic [AW-1:0] L_RP    = AW'(N_RP);
    localparam logic [AW-1:0] L_RAS   = AW'(N_RAS);
    localparam logic [AW-1:0] L_RC    = AW'(N_RC);
    localparam logic [AW-1:0] L_CDL   = AW'(N_CDL);
    localparam logic [AW-1:0] L_RDL   = AW'(N_RDL);
    localparam logic [AW-1:0] L_BDL   = AW'(N_BDL);
    localparam logic [AW-1:0] L_RDPRE = AW'(N_RDPRE);
    localparam logic [NVIOL-1:0] CMD_MASK = ~(NVIOL'(1) << V_RASMX);

    logic is_act, is_rd, is_wr, is_pre, is_bst, is_cmd;
    logic [NBANK-1:0] open_q;
    logic [NBANK-1:0] ras_max;
    logic [AW-1:0]    age_act [NBANK];
    logic [AW-1:0]    age_pre [NBANK];
    logic [AW-1:0]    age_rd  [NBANK];
    logic [AW-1:0]    wdist;
    logic [BW-1:0]    wbank;
    logic [NVIOL-1:0] viol_d, viol_q;
    logic             ok_q;

    // Decode the command code into one-hot strobes.
    always_comb begin
        is_act = (cmd_i == CMD_ACT);
        is_rd  = (cmd_i == CMD_RD);
        is_wr  = (cmd_i == CMD_WR);
        is_pre = (cmd_i == CMD_PRE);
        is_bst = (cmd_i == CMD_BST);
        is_cmd = is_act | is_rd | is_wr | is_pre | is_bst;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit;
        assign hit = (bank_i == BW'(b));
        sdr_guard_bank #(.AW(AW), .SAT(SAT), .N_RASMAX(N_RASMAX)) u_bank (
            .clk_i     (clk_i),
            .rst_n_i   (rst_n_i),
            .act_i     (is_act && hit),
            .rd_i      (is_rd && hit),
            .pre_i     (is_pre && hit),
            .open_o    (open_q[b]),
            .age_act_o (age_act[b]),
            .age_pre_o (age_pre[b]),
            .age_rd_o  (age_rd[b]),
            .ras_max_o (ras_max[b])
        );
    end

    sdr_guard_wdata #(.AW(AW), .SAT(SAT), .BW(BW)) u_wdata (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .wr_i      (is_wr),
        .wr_bank_i (bank_i),
        .strobe_i  (wr_last_i),
        .dist_o    (wdist),
        .bank_o    (wbank)
    );

    // Evaluate every rule against the command of this cycle.
    always_comb begin
        viol_d = '0;
        if (is_act) begin
            if (open_q[bank_i])               viol_d[V_STATE] = 1'b1;
            if (age_act[bank_i] < L_RC)       viol_d[V_RC]    = 1'b1;
            if (age_pre[bank_i] < L_RP)       viol_d[V_RP]    = 1'b1;
            for (int b = 0; b < NBANK; b++) begin
                if (BW'(b) != bank_i && age_act[b] < L_RRD) viol_d[V_RRD] = 1'b1;
            end
        end
        if (is_rd || is_wr) begin
            if (!open_q[bank_i])              viol_d[V_STATE] = 1'b1;
            else if (age_act[bank_i] < L_RCD) viol_d[V_RCD]   = 1'b1;
            if (wdist < L_CDL)                viol_d[V_WCOL]  = 1'b1;
        end
        if (is_pre && open_q[bank_i]) begin
            if (age_act[bank_i] < L_RAS)      viol_d[V_RAS]   = 1'b1;
            if (age_rd[bank_i] < L_RDPRE)     viol_d[V_RDPRE] = 1'b1;
            if (wbank == bank_i && wdist < L_RDL) viol_d[V_WPRE] = 1'b1;
        end
        if (is_bst && wdist < L_BDL)          viol_d[V_WBST]  = 1'b1;
        viol_d[V_RASMX] = |ras_max;
    end

    // Register flags and the ok pulse for exactly one cycle.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            viol_q <= '0;
            ok_q   <= 1'b0;
        end else begin
            viol_q <= viol_d;
            ok_q   <= is_cmd && ((viol_d & CMD_MASK) == '0);
        end
    end

    assign viol_o = viol_q;
    assign ok_o   = ok_q;

    assert_ok_clean_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ok_o |-> ((viol_o & CMD_MASK) == '0));

    assert_rrd_after_act_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        viol_o[V_RRD] |-> $past(cmd_i) == CMD_ACT);

    assert_rdpre_after_pre_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        viol_o[V_RDPRE] |-> $past(cmd_i) == CMD_PRE);

    assert_bst_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        viol_o[V_WBST] |-> $past(cmd_i) == CMD_BST);

    assert_rcd_open_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        viol_o[V_RCD] |-> !viol_o[V_STATE]);

endmodule

// File: tb/sdr_cmd_guard_tb.sv
`timescale 1ns/1ps
module sdr_cmd_guard_tb_top;
    localparam int TCK   = 5000;
    localparam int TRRD  = 10000;
    localparam int TRCD  = 15000;
    localparam int TRP   = 15000;
    localparam int TRAS  = 40000;
    localparam int TRMX  = 100000000;
    localparam int TRC   = 70000;
    localparam int CL    = 3;
    localparam int BL    = 4;
    localparam int C_RRD = (TRRD + TCK - 1) / TCK;
    localparam int C_RCD = (TRCD + TCK - 1) / TCK;
    localparam int C_RP  = (TRP + TCK - 1) / TCK;
    localparam int C_RAS = (TRAS + TCK - 1) / TCK;
    localparam int C_RMX = (TRMX + TCK - 1) / TCK;
    localparam int C_RC  = (TRC + TCK - 1) / TCK;
    localparam int C_RDP = CL + BL - 2;

    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4, BST = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd_r = NOP;
    logic [0:0]  bank_r = 1'b0;
    logic        wl_r = 1'b0;
    logic [10:0] viol;
    logic        ok;
    logic [10:0] got_v;
    logic        got_ok;
    int          n_run = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    sdr_cmd_guard #(
        .T_CK_PS(TCK), .T_RRD_PS(TRRD), .T_RCD_PS(TRCD), .T_RP_PS(TRP),
        .T_RAS_PS(TRAS), .T_RASMX_PS(TRMX), .T_RC_PS(TRC),
        .CAS_LAT(CL), .BURST_LEN(BL)
    ) dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .cmd_i(cmd_r), .bank_i(bank_r),
        .wr_last_i(wl_r), .viol_o(viol), .ok_o(ok)
    );

    function automatic logic [10:0] bit_at(input int i, input bit on);
        return on ? (11'd1 << i) : 11'd0;
    endfunction

    // Drive one cycle from a falling edge; sample just after the rising edge.
    task automatic cyc(input logic [2:0] c, input logic b, input logic w);
        cmd_r = c; bank_r = b; wl_r = w;
        @(posedge clk); #1;
        got_v = viol; got_ok = ok;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(NOP, 1'b0, 1'b0);
    endtask

    task automatic chk(input string req, input logic [10:0] ev, input logic eok);
        n_run++;
        if (got_v !== ev || got_ok !== eok) begin
            n_fail++;
            $display("FAIL %s: viol=%b ok=%b expected viol=%b ok=%b", req, got_v, got_ok, ev, eok);
        end
    endtask

    // Return to all banks closed with every timer long expired.
    task automatic settle();
        idle(20); cyc(PRE, 1'b0, 1'b0); cyc(PRE, 1'b1, 1'b0); idle(20);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [10:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, first command legal
        cyc(NOP, 1'b0, 1'b0); chk("R1 reset", '0, 1'b0);
        cyc(ACT, 1'b0, 1'b0); chk("R1 first act", '0, 1'b1);
        settle();

        // R3: ACTIVE to other bank
        for (int g = 1; g <= C_RRD + 1; g++) begin
            settle(); cyc(ACT, 1'b0, 1'b0); idle(g - 1); cyc(ACT, 1'b1, 1'b0);
            e = bit_at(0, g < C_RRD); chk("R3 rrd", e, e == '0);
        end
        // R4: ACTIVE to READ/WRITE
        for (int g = 1; g <= C_RCD + 1; g++) begin
            settle(); cyc(ACT, 1'b0, 1'b0); idle(g - 1); cyc(RD, 1'b0, 1'b0);
            e = bit_at(1, g < C_RCD); chk("R4 rcd read", e, e == '0);
        end
        settle(); cyc(ACT, 1'b1, 1'b0); cyc(WR, 1'b1, 1'b0);
        chk("R4 rcd write", bit_at(1, 1), 1'b0);
        // R6: ACTIVE to PRECHARGE
        for (int g = 1; g <= C_RAS + 1; g++) begin
            settle(); cyc(ACT, 1'b0, 1'b0); idle(g - 1); cyc(PRE, 1'b0, 1'b0);
            e = bit_at(3, g < C_RAS); chk("R6 ras", e, e == '0);
        end
        // R5: PRECHARGE to ACTIVE and ACTIVE to ACTIVE, same bank
        for (int h = 1; h <= C_RC - C_RAS + 1; h++) begin
            settle(); cyc(ACT, 1'b0, 1'b0); idle(C_RAS - 1); cyc(PRE, 1'b0, 1'b0);
            idle(h - 1); cyc(ACT, 1'b0, 1'b0);
            e = bit_at(2, h < C_RP) | bit_at(4, C_RAS + h < C_RC);
            chk("R5 rp/rc", e, e == '0);
        end
        // R7: READ to PRECHARGE
        for (int g = 1; g <= C_RDP + 1; g++) begin
            settle(); cyc(ACT, 1'b0, 1'b0); idle(C_RAS - 1); cyc(RD, 1'b0, 1'b0);
            idle(g - 1); cyc(PRE, 1'b0, 1'b0);
            e = bit_at(10, g < C_RDP); chk("R7 rd-pre", e, e == '0);
        end
        // R8: last write data to column command
        for (int g = 0; g <= 2; g++) begin
            settle(); cyc(ACT, 1'b0, 1'b0); idle(C_RAS - 1); cyc(WR, 1'b0, 1'b0); idle(3);
            if (g == 0) cyc(RD, 1'b0, 1'b1);
            else begin cyc(NOP, 1'b0, 1'b1); idle(g - 1); cyc(RD, 1'b0, 1'b0); end
            e = bit_at(7, g < 1); chk("R8 wdata-col", e, e == '0);
        end
        // R9: last write data to PRECHARGE, same bank
        for (int g = 0; g <= 3; g++) begin
            settle(); cyc(ACT, 1'b0, 1'b0); idle(C_RAS - 1); cyc(WR, 1'b0, 1'b0); idle(3);
            if (g == 0) cyc(PRE, 1'b0, 1'b1);
            else begin cyc(NOP, 1'b0, 1'b1); idle(g - 1); cyc(PRE, 1'b0, 1'b0); end
            e = bit_at(8, g < 2); chk("R9 wdata-pre", e, e == '0);
        end
        // R9: other bank is unaffected
        settle(); cyc(ACT, 1'b0, 1'b0); idle(C_RRD - 1); cyc(ACT, 1'b1, 1'b0); idle(C_RAS + 1);
        cyc(WR, 1'b0, 1'b0); idle(2); cyc(PRE, 1'b1, 1'b1);
        chk("R9 other bank", '0, 1'b1);
        // R10: last write data to BURST STOP
        for (int g = 0; g <= 2; g++) begin
            settle(); cyc(ACT, 1'b0, 1'b0); idle(C_RAS - 1); cyc(WR, 1'b0, 1'b0); idle(3);
            if (g == 0) cyc(BST, 1'b0, 1'b1);
            else begin cyc(NOP, 1'b0, 1'b1); idle(g - 1); cyc(BST, 1'b0, 1'b0); end
            e = bit_at(9, g < 1); chk("R10 wdata-bst", e, e == '0);
        end
        // R11 and R13: bank state, one-cycle flags, unused codes (R2)
        settle();
        cyc(RD, 1'b1, 1'b0); chk("R11 read closed", bit_at(6, 1), 1'b0);
        cyc(NOP, 1'b0, 1'b0); chk("R13 flag drops", '0, 1'b0);
        cyc(WR, 1'b0, 1'b0); chk("R11 write closed", bit_at(6, 1), 1'b0);
        cyc(PRE, 1'b1, 1'b0); chk("R11 pre closed", '0, 1'b1);
        cyc(3'd6, 1'b0, 1'b0); chk("R2 code 6", '0, 1'b0);
        cyc(3'd7, 1'b1, 1'b0); chk("R2 code 7", '0, 1'b0);
        cyc(ACT, 1'b0, 1'b0); idle(C_RC); cyc(ACT, 1'b0, 1'b0);
        chk("R11 act open", bit_at(6, 1), 1'b0);
        // R12: row-open limit meets a legal ACTIVE to the other bank
        settle(); cyc(ACT, 1'b0, 1'b0);
        for (int k = 1; k <= C_RMX + 1; k++) begin
            if (k == C_RMX) begin
                cyc(ACT, 1'b1, 1'b0); chk("R12 expiry with act", bit_at(5, 1), 1'b1);
            end else begin
                cyc(NOP, 1'b0, 1'b0); chk("R12 no early/late flag", '0, 1'b0);
            end
        end
        // R12: precharge in the expiry clock suppresses the flag
        settle(); cyc(ACT, 1'b0, 1'b0);
        for (int k = 1; k <= C_RMX + 1; k++) begin
            if (k == C_RMX) begin
                cyc(PRE, 1'b0, 1'b0); chk("R12 pre at limit", '0, 1'b1);
            end else begin
                cyc(NOP, 1'b0, 1'b0);
                if (k > C_RMX - 2) chk("R12 quiet", '0, 1'b0);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule